// File: doc/BRIEF.md
# Strobe-Order Memory Cycle Decoder

This block sits on the device side of an asynchronous-strobe DRAM interface. A fast synchronous clock samples the active-low row strobe, column strobe and write strobe. The block works out what kind of memory cycle the host is running from the order in which those strobes fall. It recognises four kinds of cycle: a column access, a row-only refresh, a column-before-row refresh, and a test-mode entry. For each one it emits a one-hot cycle code for a single clock. It also keeps an internal refresh row counter, holds a sticky test-mode flag, and detects self-refresh. It does not model the storage array. Instead it takes the two cell bits that the addressed column would read, and it returns the output bit and the output-enable level that the pins would show.

Inside a column access, every column strobe fall is classified as a read, an early write or a read-modify-write. In test mode a read ignores column bit 9, and the output reports whether the two cell bits agree.

The control is one state machine with five states:
- ST_IDLE: the row strobe is high.
- ST_ROW: the row is open and no column strobe has been seen yet.
- ST_COL: a column access is in progress.
- ST_REF: a column-before-row refresh is in progress.
- ST_SELF: self-refresh.

Its transitions are:
- ST_IDLE to ST_ROW: the row strobe falls while the column strobe is high.
- ST_IDLE to ST_REF: the row strobe falls while the column strobe is low.
- ST_ROW to ST_COL: the column strobe falls.
- ST_REF to ST_SELF: the row strobe has been low long enough.
- Any other state to ST_IDLE: the row strobe returns high.

Top module: `strobe_cycle_decoder`

## Requirements
- R1: After reset, cyc_type is 0, test_mode is 0, self_refresh is 0, dq_oe is 0 and the refresh counter is 0.
- R2: Suppose the row strobe is sampled falling while the column strobe is low and the write strobe is high. Then on the following clock cyc_type is 4'b0100 (bit 2, refresh). act_row carries the refresh counter value, and the counter advances by one.
- R3: Suppose the row strobe is sampled falling while both the column strobe and the write strobe are low. Then cyc_type is 4'b1000 (bit 3, test entry) and test_mode becomes 1. This cycle also uses and advances the refresh counter.
- R4: Suppose the row strobe falls with the column strobe high and rises again with no column strobe fall in between. Then cyc_type is 4'b0010 (bit 1, row-only refresh) on the clock after the rise is sampled. act_row holds the address that was sampled at the row strobe fall.
- R5: The first column strobe fall after a row opens gives cyc_type 4'b0001 (bit 0, access) on the next clock. Later column strobe falls in the same row cycle, and the row strobe rise that ends it, give cyc_type 0.
- R6: test_mode stays set through accesses. It is cleared by a row-only refresh or by a refresh with the write strobe high.
- R7: If the write strobe is low when a column strobe fall is sampled, wr_early pulses for one clock and dq_oe is 0.
- R8: If the write strobe falls while the column strobe is held low after a read column, wr_rmw pulses for one clock.
- R9: A read column sets dq_oe to 1. Outside test mode, dq_out is cell_bits indexed by address bit 9. In test mode, address bit 9 is ignored and dq_out is 1 when cell_bits[0] equals cell_bits[1], and 0 otherwise.
- R10: In a refresh or test-entry cycle, self_refresh rises on the clock where the row strobe has been sampled low SELF_CYC times in a row. It clears on the clock after the row strobe is sampled high.
- R11: The refresh counter is ROW_W (11) bits wide and wraps from 2047 to 0.
- R12: Suppose the row strobe rise and a column strobe fall are sampled on the same clock while the row is open. The cycle is then a row-only refresh, not an access.
- R13: At most one bit of cyc_type is ever set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| addr | input | ROW_W | Multiplexed row/column address |
| cell_bits | input | 2 | The two cell bits the addressed column reads |
| cyc_type | output | 4 | One-hot cycle code: 0 access, 1 row-only refresh, 2 refresh, 3 test entry |
| act_row | output | ROW_W | Row used by the latest cycle |
| test_mode | output | 1 | Sticky test-mode flag |
| self_refresh | output | 1 | Self-refresh active |
| wr_early | output | 1 | Early-write column pulse |
| wr_rmw | output | 1 | Read-modify-write pulse |
| dq_oe | output | 1 | Output drive enable |
| dq_out | output | 1 | Output data bit |

## Verification
Two functions can land on the same clock: the row strobe rise that completes a row-only refresh, and the column strobe fall that would start an access. The bench lowers the column strobe on exactly the sample where it raises the row strobe. It then expects a row-only refresh code with no access code, and a cleared test-mode flag. A second overlap is test-mode exit happening in the same cycle as refresh-counter use. A refresh with the write strobe high, issued while in test mode, must both clear the flag and advance the counter.

// File: rtl/scd_pkg.sv
package scd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ROW,
        ST_COL,
        ST_REF,
        ST_SELF
    } scd_state_t;

    localparam int CT_ACC  = 0;
    localparam int CT_ROR  = 1;
    localparam int CT_CBR  = 2;
    localparam int CT_TEST = 3;
    localparam int CT_W    = 4;

endpackage

// File: rtl/scd_edge.sv
module scd_edge #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl_n,
    output logic [N-1:0] fall
);
    logic [N-1:0] prev_q;

    for (genvar g = 0; g < N; g++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n) prev_q[g] <= 1'b1;
            else        prev_q[g] <= lvl_n[g];
        end
        assign fall[g] = prev_q[g] & ~lvl_n[g];
    end
endmodule

// File: rtl/scd_refresh_ctr.sv
module scd_refresh_ctr #(
    parameter int ROW_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    output logic [ROW_W-1:0] count
);
    always_ff @(posedge clk) begin
        if (!rst_n)    count <= '0;
        else if (step) count <= count + 1'b1;
    end
endmodule

// File: rtl/scd_fsm.sv
module scd_fsm
    import scd_pkg::*;
#(
    parameter int ROW_W    = 11,
    parameter int COL_W    = 10,
    parameter int SELF_CYC = 10000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ras_n,
    input  logic             cas_n,
    input  logic             we_n,
    input  logic             ras_fall,
    input  logic             cas_fall,
    input  logic             we_fall,
    input  logic [ROW_W-1:0] addr,
    input  logic [1:0]       cell_bits,
    input  logic [ROW_W-1:0] ref_row,
    output logic             ref_step,
    output logic [CT_W-1:0]  cyc_type,
    output logic [ROW_W-1:0] act_row,
    output logic             test_mode,
    output logic             self_refresh,
    output logic             wr_early,
    output logic             wr_rmw,
    output logic             dq_oe,
    output logic             dq_out
);
    localparam int CNT_W = $clog2(SELF_CYC + 1);

    scd_state_t       state, state_nx;
    logic [CNT_W-1:0] low_cnt;
    logic             low_hit;
    logic             col_bit;
    logic             rd_bit;

    assign low_hit  = (low_cnt == CNT_W'(SELF_CYC - 1));
    assign ref_step = (state == ST_IDLE) && ras_fall && !cas_n;
    assign col_bit  = addr[COL_W-1];
    assign rd_bit   = test_mode ? ~(cell_bits[0] ^ cell_bits[1]) : cell_bits[col_bit];

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (ras_fall) state_nx = cas_n ? ST_ROW : ST_REF;
            ST_ROW:  if (ras_n) state_nx = ST_IDLE;
                     else if (cas_fall) state_nx = ST_COL;
            ST_COL:  if (ras_n) state_nx = ST_IDLE;
            ST_REF:  if (ras_n) state_nx = ST_IDLE;
                     else if (low_hit) state_nx = ST_SELF;
            ST_SELF: if (ras_n) state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_cnt <= '0;
        end else if (ref_step) begin
            low_cnt <= CNT_W'(1);
        end else if (state == ST_REF && !ras_n) begin
            low_cnt <= low_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc_type     <= '0;
            act_row      <= '0;
            test_mode    <= 1'b0;
            self_refresh <= 1'b0;
            wr_early     <= 1'b0;
            wr_rmw       <= 1'b0;
            dq_oe        <= 1'b0;
            dq_out       <= 1'b0;
        end else begin
            cyc_type <= '0;
            wr_early <= 1'b0;
            wr_rmw   <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (ras_fall) begin
                        if (!cas_n) begin
                            act_row <= ref_row;
                            if (!we_n) begin
                                cyc_type[CT_TEST] <= 1'b1;
                                test_mode         <= 1'b1;
                            end else begin
                                cyc_type[CT_CBR] <= 1'b1;
                                test_mode        <= 1'b0;
                            end
                        end else begin
                            act_row <= addr;
                        end
                    end
                end
                ST_ROW, ST_COL: begin
                    if (ras_n) begin
                        dq_oe <= 1'b0;
                        if (state == ST_ROW) begin
                            cyc_type[CT_ROR] <= 1'b1;
                            test_mode        <= 1'b0;
                        end
                    end else if (cas_fall) begin
                        if (state == ST_ROW) cyc_type[CT_ACC] <= 1'b1;
                        if (!we_n) begin
                            wr_early <= 1'b1;
                            dq_oe    <= 1'b0;
                        end else begin
                            dq_oe  <= 1'b1;
                            dq_out <= rd_bit;
                        end
                    end else if (state == ST_COL && we_fall && !cas_n && dq_oe) begin
                        wr_rmw <= 1'b1;
                    end
                end
                ST_REF, ST_SELF: begin
                    if (ras_n)        self_refresh <= 1'b0;
                    else if (low_hit && state == ST_REF) self_refresh <= 1'b1;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/strobe_cycle_decoder.sv
module strobe_cycle_decoder
    import scd_pkg::*;
#(
    parameter int ROW_W    = 11,
    parameter int COL_W    = 10,
    parameter int SELF_CYC = 10000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ras_n,
    input  logic             cas_n,
    input  logic             we_n,
    input  logic [ROW_W-1:0] addr,
    input  logic [1:0]       cell_bits,
    output logic [CT_W-1:0]  cyc_type,
    output logic [ROW_W-1:0] act_row,
    output logic             test_mode,
    output logic             self_refresh,
    output logic             wr_early,
    output logic             wr_rmw,
    output logic             dq_oe,
    output logic             dq_out
);
    logic [2:0]       falls;
    logic [ROW_W-1:0] ref_cnt;
    logic             ref_step;

    scd_edge #(.N(3)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl_n ({we_n, cas_n, ras_n}),
        .fall  (falls)
    );

    scd_refresh_ctr #(.ROW_W(ROW_W)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (ref_step),
        .count (ref_cnt)
    );

    scd_fsm #(.ROW_W(ROW_W), .COL_W(COL_W), .SELF_CYC(SELF_CYC)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .ras_n        (ras_n),
        .cas_n        (cas_n),
        .we_n         (we_n),
        .ras_fall     (falls[0]),
        .cas_fall     (falls[1]),
        .we_fall      (falls[2]),
        .addr         (addr),
        .cell_bits    (cell_bits),
        .ref_row      (ref_cnt),
        .ref_step     (ref_step),
        .cyc_type     (cyc_type),
        .act_row      (act_row),
        .test_mode    (test_mode),
        .self_refresh (self_refresh),
        .wr_early     (wr_early),
        .wr_rmw       (wr_rmw),
        .dq_oe        (dq_oe),
        .dq_out       (dq_out)
    );
endmodule

// File: rtl/scd_checker.sv
module scd_checker
    import scd_pkg::*;
#(
    parameter int ROW_W = 11
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ras_n,
    input logic             cas_n,
    input logic             we_n,
    input logic [CT_W-1:0]  cyc_type,
    input logic             test_mode,
    input logic             self_refresh,
    input logic             wr_early,
    input logic             wr_rmw,
    input logic             dq_oe,
    input logic [ROW_W-1:0] ref_cnt
);
    assert_onehot_type_R13: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cyc_type));

    assert_refresh_class_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ras_n && $past(ras_n) && !cas_n && we_n) |=> cyc_type[CT_CBR]);

    assert_counter_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!ras_n && $past(ras_n) && !cas_n) |=> (ref_cnt == ROW_W'($past(ref_cnt) + 1'b1)));

    assert_test_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(test_mode) |-> cyc_type[CT_TEST]);

    assert_test_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(test_mode) |-> (cyc_type[CT_ROR] || cyc_type[CT_CBR]));

    assert_early_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_early |-> !dq_oe);

    assert_rmw_after_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_rmw |-> (!wr_early && dq_oe));

    assert_self_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (self_refresh && ras_n) |=> !self_refresh);

    assert_self_needs_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(self_refresh) |-> !$past(ras_n));
endmodule

bind strobe_cycle_decoder scd_checker #(.ROW_W(ROW_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ras_n        (ras_n),
    .cas_n        (cas_n),
    .we_n         (we_n),
    .cyc_type     (cyc_type),
    .test_mode    (test_mode),
    .self_refresh (self_refresh),
    .wr_early     (wr_early),
    .wr_rmw       (wr_rmw),
    .dq_oe        (dq_oe),
    .ref_cnt      (ref_cnt)
);

// File: tb/strobe_cycle_decoder_tb.sv
module strobe_cycle_decoder_tb;
    localparam int CLK_PERIOD = 10;
    localparam int ROW_W      = 11;
    localparam int COL_W      = 10;
    localparam int SELF_CYC   = 20;
    localparam int CTR_MOD    = 1 << ROW_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [ROW_W-1:0] addr = '0;
    logic [1:0]       cell_bits = 2'b00;
    logic [3:0]       cyc_type;
    logic [ROW_W-1:0] act_row;
    logic             test_mode, self_refresh, wr_early, wr_rmw, dq_oe, dq_out;

    int checks = 0;
    int failures = 0;
    int exp_ctr = 0;
    bit exp_tm = 1'b0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    strobe_cycle_decoder #(.ROW_W(ROW_W), .COL_W(COL_W), .SELF_CYC(SELF_CYC)) u_dut (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .addr(addr), .cell_bits(cell_bits), .cyc_type(cyc_type), .act_row(act_row),
        .test_mode(test_mode), .self_refresh(self_refresh), .wr_early(wr_early),
        .wr_rmw(wr_rmw), .dq_oe(dq_oe), .dq_out(dq_out)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic refresh_cycle(input bit w);
        cas_n = 1'b0; we_n = w; tick();
        ras_n = 1'b0; tick();
        chk(cyc_type == (w ? 4'b0100 : 4'b1000), w ? "R2 code" : "R3 code", cyc_type, w ? 4 : 8);
        chk(act_row == ROW_W'(exp_ctr), "R11 counter row", act_row, exp_ctr);
        exp_ctr = (exp_ctr + 1) % CTR_MOD;
        exp_tm = !w;
        chk(test_mode == exp_tm, "R6 flag after refresh", test_mode, exp_tm);
        ras_n = 1'b1; tick();
        cas_n = 1'b1; we_n = 1'b1; tick();
    endtask

    task automatic row_only(input int row);
        addr = ROW_W'(row); ras_n = 1'b0; tick();
        chk(cyc_type == 4'b0000, "R4 no code at open", cyc_type, 0);
        addr = '0; ras_n = 1'b1; tick();
        chk(cyc_type == 4'b0010, "R4 code", cyc_type, 2);
        chk(act_row == ROW_W'(row), "R4 row", act_row, row);
        exp_tm = 1'b0;
        chk(test_mode == 1'b0, "R6 exit by row-only", test_mode, 0);
        tick();
    endtask

    task automatic open_row(input int row);
        addr = ROW_W'(row); ras_n = 1'b0; tick();
        chk(act_row == ROW_W'(row), "R5 open row", act_row, row);
    endtask

    task automatic col_read(input bit msb, input bit [1:0] bits, input bit first, input bit rmw);
        bit expd;
        expd = exp_tm ? (bits[0] == bits[1]) : bits[msb];
        addr = ROW_W'({msb, 9'h055}); cell_bits = bits; cas_n = 1'b0; tick();
        chk(cyc_type == (first ? 4'b0001 : 4'b0000), "R5 access code", cyc_type, first ? 1 : 0);
        chk(dq_oe == 1'b1, "R9 oe", dq_oe, 1);
        chk(dq_out == expd, "R9 data", dq_out, expd);
        chk(wr_early == 1'b0, "R7 no early on read", wr_early, 0);
        if (rmw) begin
            we_n = 1'b0; tick();
            chk(wr_rmw == 1'b1, "R8 rmw pulse", wr_rmw, 1);
            tick();
            chk(wr_rmw == 1'b0, "R8 rmw single", wr_rmw, 0);
            we_n = 1'b1;
        end
        cas_n = 1'b1; tick();
    endtask

    task automatic col_write(input bit first);
        we_n = 1'b0; cas_n = 1'b0; tick();
        chk(wr_early == 1'b1, "R7 early pulse", wr_early, 1);
        chk(dq_oe == 1'b0, "R7 output off", dq_oe, 0);
        chk(wr_rmw == 1'b0, "R8 no rmw on early", wr_rmw, 0);
        chk(cyc_type == (first ? 4'b0001 : 4'b0000), "R5 code on write", cyc_type, first ? 1 : 0);
        cas_n = 1'b1; we_n = 1'b1; tick();
    endtask

    task automatic close_row();
        ras_n = 1'b1; tick();
        chk(cyc_type == 4'b0000, "R5 no code at close", cyc_type, 0);
        chk(test_mode == exp_tm, "R6 sticky", test_mode, exp_tm);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=1 expected=0");
            finish_run();
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1; tick();
        chk(cyc_type == 0, "R1 type", cyc_type, 0);
        chk(test_mode == 0, "R1 test", test_mode, 0);
        chk(self_refresh == 0, "R1 self", self_refresh, 0);
        chk(dq_oe == 0, "R1 oe", dq_oe, 0);

        refresh_cycle(1'b1);
        refresh_cycle(1'b1);
        row_only(1234);

        open_row(77);
        for (int b = 0; b < 8; b++) col_read(b[2], b[1:0], b == 0, 1'b0);
        col_write(1'b0);
        col_read(1'b1, 2'b10, 1'b0, 1'b1);
        close_row();

        open_row(5);
        col_write(1'b1);
        close_row();

        refresh_cycle(1'b0);
        open_row(300);
        for (int b = 0; b < 8; b++) col_read(b[2], b[1:0], b == 0, 1'b0);
        close_row();
        refresh_cycle(1'b1);

        refresh_cycle(1'b0);
        row_only(2047);

        refresh_cycle(1'b0);
        addr = ROW_W'(99); ras_n = 1'b0; tick();
        ras_n = 1'b1; cas_n = 1'b0; tick();
        chk(cyc_type == 4'b0010, "R12 rise wins", cyc_type, 2);
        chk(test_mode == 1'b0, "R12 exit", test_mode, 0);
        exp_tm = 1'b0;
        cas_n = 1'b1; tick();

        cas_n = 1'b0; tick();
        ras_n = 1'b0;
        for (int k = 0; k < SELF_CYC - 1; k++) tick();
        chk(self_refresh == 1'b0, "R10 not yet", self_refresh, 0);
        chk(act_row == ROW_W'(exp_ctr), "R2 self row", act_row, exp_ctr);
        exp_ctr = (exp_ctr + 1) % CTR_MOD;
        tick();
        chk(self_refresh == 1'b1, "R10 entered", self_refresh, 1);
        repeat (5) tick();
        chk(self_refresh == 1'b1, "R10 held", self_refresh, 1);
        ras_n = 1'b1; tick();
        chk(self_refresh == 1'b0, "R10 left", self_refresh, 0);
        cas_n = 1'b1; tick();

        while (exp_ctr != 0) refresh_cycle(1'b1);
        refresh_cycle(1'b1);
        chk(exp_ctr == 1, "R11 wrap seen", exp_ctr, 1);

        done = 1'b1;
        finish_run();
    end
endmodule